// File: doc/BRIEF.md
# IR Carrier Window Demodulator

This block is the receive front end for a consumer infrared input. It synchronises the raw detector signal and times each carrier cycle from one rising edge to the next. It then checks whether that cycle's period falls inside a programmable tolerance window centred on a nominal carrier period. When enough cycles in a row pass the check, the block declares a mark on its envelope output. When the carrier stops arriving, the envelope returns to space. A separate active flag stays high for a fixed idle time after the last mark.

The nominal carrier is given as a period in sample ticks. The tolerance is set by a 3-bit range value n, which gives a window of ±n/16 of that period, about 6.25 % per step. There are two bands. In the high-speed band, meant for carriers of roughly 400 to 500 kHz, every clock is a sample tick. In the low-speed band, meant for roughly 27 to 58 kHz, a prescaler makes one tick every LOW_DIV clocks. Clearing the demodulator enable skips the carrier check, and the sampled input is copied straight to the envelope. Clearing the receiver enable silences the whole block.

Top module: `ir_carrier_demod`

## Requirements
- R1: A carrier cycle is accepted when its measured period M, in sample ticks, satisfies P - T <= M <= P + T. Here P is the captured centre period and T = (P * n) >> 4. The envelope becomes mark on the second accepted cycle in a row.
- R2: A cycle whose period lies outside the window is rejected and clears the run of accepted cycles. A burst made only of such cycles never produces a mark.
- R3: The centre period, range and band are captured only while the receiver enable is low. While it is high they stay frozen. Reset loads period DEF_PERIOD, range 1 and the high-speed band.
- R4: With the band select high, every clock is a sample tick. With it low, one tick occurs every LOW_DIV clocks, so the same tick count spans LOW_DIV times as many clocks.
- R5: In demodulation mode the envelope returns to space once 2 * P sample ticks pass with no accepted rising edge.
- R6: With the demodulator enable low, no window check is made and the envelope follows the synchronised, tick-sampled input, with a latency of a few clocks.
- R7: With the receiver enable low, the envelope and the active flag are both driven low, starting from the next clock.
- R8: The active flag is high whenever the envelope is mark. It clears after 256 sample ticks in a row without a mark.
- R9: A range value of 0 gives zero tolerance, so only cycles of exactly P ticks are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irIn | input | 1 | Raw detector input, asynchronous |
| centerPeriod | input | PW | Nominal carrier period in sample ticks |
| rangeSel | input | 3 | Tolerance steps n, each n/16 of the period |
| highBand | input | 1 | 1 selects the high-speed band (tick every clock) |
| demodEn | input | 1 | 1 enables the carrier window check, 0 selects bypass |
| rxEn | input | 1 | Receiver enable; configuration is captured while it is low |
| envelope | output | 1 | Demodulated envelope, 1 = mark |
| active | output | 1 | Reception-in-progress flag |

## Verification
The hardest situation to reach from the ports is showing that the reset-time range value is really in use. The range is captured only while the receiver is disabled. So the bench holds the receiver enable high straight out of reset and drives a very different range and period on the inputs. It then shows that a carrier just outside the ±1 step window still gets no mark. The window edges are found with carriers one tick inside and one tick outside the computed bounds, on both sides. A long quiet stretch is placed before each burst, so the first edge is always rejected against a saturated counter.

// File: rtl/ir_demod_pkg.sv
package ir_demod_pkg;
  // strobes passed from the datapath to the control each clock
  typedef struct packed {
    logic tick;        // sample tick for the selected band
    logic sample;      // current tick-sampled input level
    logic accepted;    // rising edge closing an in-window cycle
    logic rejected;    // rising edge closing an out-of-window cycle
    logic gapExpired;  // 2 * P ticks since the last accepted edge
  } dpStrobe_t;
endpackage

// File: rtl/ir_demod_datapath.sv
module ir_demod_datapath
  import ir_demod_pkg::*;
#(
  parameter int PW = 12,
  parameter int LOW_DIV = 4,
  parameter int DEF_PERIOD = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irIn,
  input  logic [PW-1:0] centerPeriod,
  input  logic [2:0]    rangeSel,
  input  logic          highBand,
  input  logic          rxEn,
  output dpStrobe_t     strobes
);
  localparam int DIVW = (LOW_DIV > 1) ? $clog2(LOW_DIV) : 1;
  localparam logic [PW-1:0] PMAX = {PW{1'b1}};
  localparam logic [PW:0]   GMAX = {(PW+1){1'b1}};

  logic [PW-1:0] cfgPeriod;
  logic [2:0]    cfgRange;
  logic          cfgHigh;
  logic [1:0]    syncQ;
  logic [DIVW-1:0] divCnt;
  logic          tick, irSmp, rise, inWin;
  logic [PW-1:0] periodCnt;
  logic [PW:0]   gapCnt, measured, winLo, winHi, gapLimit;
  logic [PW+2:0] prod;
  logic [PW-2:0] tol;

  // configuration capture, only while the receiver is off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgPeriod <= PW'(DEF_PERIOD);
      cfgRange  <= 3'd1;
      cfgHigh   <= 1'b1;
    end else if (!rxEn) begin
      cfgPeriod <= centerPeriod;
      cfgRange  <= rangeSel;
      cfgHigh   <= highBand;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= 2'b00;
    else        syncQ <= {syncQ[0], irIn};
  end

  // band prescaler
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            divCnt <= '0;
    else if (cfgHigh)                      divCnt <= '0;
    else if (divCnt == DIVW'(LOW_DIV - 1)) divCnt <= '0;
    else                                   divCnt <= divCnt + 1'b1;
  end
  assign tick = cfgHigh | (divCnt == DIVW'(LOW_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irSmp <= 1'b0;
    else if (!rxEn) irSmp <= 1'b0;
    else if (tick)  irSmp <= syncQ[1];
  end
  assign rise = rxEn & tick & syncQ[1] & ~irSmp;

  // period measurement between rising edges, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 periodCnt <= PMAX;
    else if (!rxEn)             periodCnt <= PMAX;
    else if (tick) begin
      if (rise)                 periodCnt <= '0;
      else if (periodCnt != PMAX) periodCnt <= periodCnt + 1'b1;
    end
  end

  // tolerance window
  assign prod     = cfgPeriod * cfgRange;
  assign tol      = prod[PW+2:4];
  assign measured = {1'b0, periodCnt} + (PW+1)'(1);
  assign winLo    = {1'b0, cfgPeriod} - {2'b00, tol};
  assign winHi    = {1'b0, cfgPeriod} + {2'b00, tol};
  assign inWin    = (measured >= winLo) && (measured <= winHi);

  // ticks since the last accepted edge
  assign gapLimit = {cfgPeriod, 1'b0};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  gapCnt <= GMAX;
    else if (!rxEn)              gapCnt <= GMAX;
    else if (tick) begin
      if (strobes.accepted)      gapCnt <= '0;
      else if (gapCnt != GMAX)   gapCnt <= gapCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.tick       = tick;
    strobes.sample     = irSmp;
    strobes.accepted   = rise & inWin;
    strobes.rejected   = rise & ~inWin;
    strobes.gapExpired = tick & (gapCnt >= gapLimit);
  end
endmodule

// File: rtl/ir_demod_control.sv
module ir_demod_control
  import ir_demod_pkg::*;
#(
  parameter int IDLE_TICKS = 256
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rxEn,
  input  logic      demodEn,
  input  dpStrobe_t strobes,
  output logic      envelope,
  output logic      active
);
  localparam int IW = (IDLE_TICKS > 1) ? $clog2(IDLE_TICKS) : 1;

  logic [1:0]    streak, streakNext;
  logic          envNext;
  logic [IW-1:0] idleCnt;

  always_comb begin
    envNext    = envelope;
    streakNext = streak;
    if (!rxEn) begin
      envNext    = 1'b0;
      streakNext = '0;
    end else if (!demodEn) begin
      envNext    = strobes.sample;
      streakNext = '0;
    end else if (strobes.accepted) begin
      streakNext = (streak == 2'd2) ? 2'd2 : streak + 1'b1;
      if (streakNext == 2'd2) envNext = 1'b1;
    end else if (strobes.rejected) begin
      streakNext = '0;
      if (strobes.gapExpired) envNext = 1'b0;
    end else if (strobes.gapExpired) begin
      streakNext = '0;
      envNext    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      envelope <= 1'b0;
      streak   <= '0;
    end else begin
      envelope <= envNext;
      streak   <= streakNext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      idleCnt <= '0;
    end else if (!rxEn) begin
      active  <= 1'b0;
      idleCnt <= '0;
    end else if (envNext) begin
      active  <= 1'b1;
      idleCnt <= '0;
    end else if (strobes.tick && active) begin
      if (idleCnt == IW'(IDLE_TICKS - 1)) begin
        active  <= 1'b0;
        idleCnt <= '0;
      end else begin
        idleCnt <= idleCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ir_carrier_demod.sv
module ir_carrier_demod
  import ir_demod_pkg::*;
#(
  parameter int PW = 12,
  parameter int LOW_DIV = 4,
  parameter int DEF_PERIOD = 20,
  parameter int IDLE_TICKS = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irIn,
  input  logic [PW-1:0] centerPeriod,
  input  logic [2:0]    rangeSel,
  input  logic          highBand,
  input  logic          demodEn,
  input  logic          rxEn,
  output logic          envelope,
  output logic          active
);
  dpStrobe_t strobes;

  ir_demod_datapath #(.PW(PW), .LOW_DIV(LOW_DIV), .DEF_PERIOD(DEF_PERIOD)) u_dp (
    .clk(clk), .rst_n(rst_n), .irIn(irIn), .centerPeriod(centerPeriod),
    .rangeSel(rangeSel), .highBand(highBand), .rxEn(rxEn), .strobes(strobes)
  );

  ir_demod_control #(.IDLE_TICKS(IDLE_TICKS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .rxEn(rxEn), .demodEn(demodEn),
    .strobes(strobes), .envelope(envelope), .active(active)
  );
endmodule

// File: rtl/ir_carrier_demod_chk.sv
module ir_carrier_demod_chk
  import ir_demod_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      rxEn,
  input logic      demodEn,
  input logic      envelope,
  input logic      active,
  input dpStrobe_t strobes
);
  AST_ENV_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !rxEn |=> !envelope); // R7
  AST_ACT_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !rxEn |=> !active); // R7
  AST_ACTIVE_COVERS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    envelope |-> active); // R8
  AST_MARK_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(envelope) && $past(demodEn)) |-> $past(strobes.accepted)); // R1
  AST_GAP_DROPS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.gapExpired && !strobes.accepted && demodEn && rxEn) |=> !envelope); // R5
endmodule

bind ir_carrier_demod ir_carrier_demod_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rxEn(rxEn), .demodEn(demodEn),
  .envelope(envelope), .active(active), .strobes(strobes)
);

// File: tb/ir_carrier_demod_test.sv
module ir_carrier_demod_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irIn = 1'b0;
  logic [11:0] centerPeriod = 12'd100;
  logic [2:0] rangeSel = 3'd7;
  logic highBand = 1'b0;
  logic demodEn = 1'b1;
  logic rxEn = 1'b1;
  logic envelope, active;
  int checks = 0;
  int fails = 0;
  bit sawMark;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ir_carrier_demod uut (
    .clk(clk), .rst_n(rst_n), .irIn(irIn), .centerPeriod(centerPeriod),
    .rangeSel(rangeSel), .highBand(highBand), .demodEn(demodEn),
    .rxEn(rxEn), .envelope(envelope), .active(active)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic quiet(input int n);
    irIn = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // n carrier cycles of t clocks each; records any mark seen
  task automatic carrier(input int t, input int n);
    sawMark = 1'b0;
    for (int c = 0; c < n; c++) begin
      for (int i = 0; i < t; i++) begin
        irIn = (i < t / 2);
        @(negedge clk);
        if (envelope) sawMark = 1'b1;
      end
    end
    irIn = 1'b0;
  endtask

  task automatic setCfg(input int p, input int r, input logic h);
    @(negedge clk);
    rxEn = 1'b0;
    centerPeriod = 12'(p);
    rangeSel = 3'(r);
    highBand = h;
    repeat (3) @(negedge clk);
    rxEn = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R7", "reset envelope", envelope, 1'b0);
    check("R8", "reset active", active, 1'b0);
  endtask

  // receiver held on since reset: period 20, range 1, high band in force
  task automatic t_resetConfig;
    quiet(10);
    carrier(20, 6);
    check("R3", "reset period 20 accepted", envelope, 1'b1);
    quiet(80);
    check("R3", "mark falls after burst", envelope, 1'b0);
    carrier(22, 6);
    check("R3", "22 outside reset range 1", sawMark, 1'b0);
    quiet(80);
  endtask

  task automatic t_window;
    setCfg(40, 2, 1'b1); // tolerance 5
    quiet(150);
    carrier(45, 6); check("R1", "upper bound 45 accepted", envelope, 1'b1);
    quiet(150);
    carrier(35, 6); check("R1", "lower bound 35 accepted", envelope, 1'b1);
    quiet(150);
    carrier(46, 6); check("R2", "46 above window", sawMark, 1'b0);
    quiet(150);
    carrier(34, 6); check("R2", "34 below window", sawMark, 1'b0);
    quiet(150);
  endtask

  task automatic t_exact;
    setCfg(30, 0, 1'b1);
    quiet(100);
    carrier(30, 6); check("R9", "exact 30 accepted", envelope, 1'b1);
    quiet(100);
    carrier(31, 6); check("R9", "31 rejected at range 0", sawMark, 1'b0);
    quiet(100);
    carrier(29, 6); check("R9", "29 rejected at range 0", sawMark, 1'b0);
    quiet(100);
  endtask

  task automatic t_gap;
    setCfg(40, 2, 1'b1);
    quiet(150);
    carrier(40, 6);
    quiet(34); // 74 clocks since last edge
    check("R5", "mark held inside 2P", envelope, 1'b1);
    quiet(18); // 92 clocks since last edge
    check("R5", "space after 2P", envelope, 1'b0);
    check("R8", "active held after fall", active, 1'b1);
    quiet(300);
    check("R8", "active clears after idle", active, 1'b0);
  endtask

  task automatic t_lowBand;
    setCfg(10, 2, 1'b0); // 10 ticks, tolerance 1, 4 clocks per tick
    quiet(200);
    carrier(40, 6); check("R4", "40 clocks = 10 ticks accepted", envelope, 1'b1);
    quiet(200);
    carrier(48, 6); check("R4", "48 clocks = 12 ticks rejected", sawMark, 1'b0);
    quiet(200);
  endtask

  task automatic t_bypass;
    demodEn = 1'b0;
    setCfg(40, 1, 1'b1);
    irIn = 1'b1;
    repeat (10) @(negedge clk);
    check("R6", "bypass follows high", envelope, 1'b1);
    check("R8", "active with bypass mark", active, 1'b1);
    irIn = 1'b0;
    repeat (10) @(negedge clk);
    check("R6", "bypass follows low", envelope, 1'b0);
  endtask

  task automatic t_disable;
    irIn = 1'b1;
    repeat (10) @(negedge clk);
    rxEn = 1'b0;
    repeat (10) @(negedge clk);
    check("R7", "disabled envelope", envelope, 1'b0);
    check("R7", "disabled active", active, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_resetConfig();
    t_window();
    t_exact();
    t_gap();
    t_lowBand();
    t_bypass();
    t_disable();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule